// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

A 16-bit up-counter paired with a 16-bit capture/reload register. An 8-bit control register sets the counter running, chooses between a system tick and falling edges on an external count pin as the count source, and decides what a falling edge on an external trigger pin does. The trigger edge can either load the counter from the capture/reload register or copy the counter into it. When the counter passes 0xFFFF, it reloads from that register in reload mode and wraps to zero in capture mode.

Either of two baud-select bits switches the block into baud generation. In that mode every overflow reloads the counter, and the block sends a one-cycle pulse to the serial receive clock, the transmit clock, or both. The overflow flag stays clear in this mode. A direction whose select bit is clear passes the other timer's baud input through unchanged. An overflow flag and an external-event flag feed an interrupt output that an enable input gates. Software accesses the registers through a simple byte-wide bus, and software clears the flags.

Top module: `cr_timer16`

## Requirements
- R1: After reset every register reads 0x00 and the outputs `irq_o`, `rx_baud_o` and `tx_baud_o` are low.
- R2: With run set and count-source clear, the counter increments once per cycle in which `tick_i` is high. With run clear or `tick_i` low, the counter holds its value.
- R3: With run and count-source set, the counter increments once per falling edge of `ext_cnt_i`. It does not increment on rising edges and ignores `tick_i`.
- R4: With capture-select clear and both baud bits clear, an increment from 0xFFFF loads the counter from the capture/reload register and sets the overflow flag (control bit 7).
- R5: With capture-select set and both baud bits clear, an increment from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R6: Outside baud mode, with external-enable set and capture-select clear, a falling edge on `ext_trig_i` loads the counter from the capture/reload register and sets the external flag (control bit 6). This happens even while run is clear.
- R7: Outside baud mode, with external-enable and capture-select both set, a falling edge on `ext_trig_i` copies the counter into the capture/reload register and sets the external flag. The counter does not change.
- R8: With external-enable clear, edges on `ext_trig_i` leave the counter, the capture/reload register and the external flag unchanged.
- R9: With receive-select (bit 5) or transmit-select (bit 4) set, each overflow reloads the counter and produces a one-cycle high pulse on the selected baud output, and the overflow flag stays clear. A baud output whose select bit is clear follows `other_rx_clk_i` or `other_tx_clk_i`.
- R10: `irq_o` is high exactly when `irq_en_i` is high and either flag is set. Writing 0 to a flag bit clears it.
- R11: Register map on `addr`: 0 control (bit 7 overflow flag, 6 external flag, 5 receive-select, 4 transmit-select, 3 external-enable, 2 run, 1 count-source, 0 capture-select), 1 counter low, 2 counter high, 3 capture low, 4 capture high. A bus write to a counter byte takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tick_i | input | 1 | Internal count tick |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| ext_trig_i | input | 1 | External capture/reload trigger pin (asynchronous) |
| other_rx_clk_i | input | 1 | Receive baud pulse from the other timer |
| other_tx_clk_i | input | 1 | Transmit baud pulse from the other timer |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| rx_baud_o | output | 1 | Serial receive baud clock |
| tx_baud_o | output | 1 | Serial transmit baud clock |

## Verification
Several properties are checked on every cycle. The counter holds while stopped. An overflow either reloads or wraps, depending on the mode. A capture copies the counter value of the previous cycle. The overflow flag never rises in baud mode, and the external flag cannot rise while external-enable is clear. The interrupt stays low while disabled. Only the bench scenarios can show the rest: whether falling edges are counted and rising edges are not, the count of baud pulses on each direction, the pass-through of the other timer's clocks, the precedence of bus writes over increments, and the register values seen after a full synchronizer delay.

// File: rtl/cr_timer16.sv
module cr_timer16 #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_i,
  input  logic       ext_cnt_i,
  input  logic       ext_trig_i,
  input  logic       other_rx_clk_i,
  input  logic       other_tx_clk_i,
  input  logic       irq_en_i,
  output logic       irq_o,
  output logic       rx_baud_o,
  output logic       tx_baud_o
);

  localparam int SW = SYNC_DEPTH + 1;

  logic [15:0]   cnt, cap;
  logic          tf, exf, rsel, tsel, exen, run, csrc, cmode;
  logic          ovf_q;
  logic [SW-1:0] cs, ts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs <= '0;
      ts <= '0;
    end else begin
      cs <= {cs[SW-2:0], ext_cnt_i};
      ts <= {ts[SW-2:0], ext_trig_i};
    end

  wire cfall    = cs[SW-1] & ~cs[SW-2];
  wire tfall    = ts[SW-1] & ~ts[SW-2];
  wire baud     = rsel | tsel;
  wire step     = run & (csrc ? cfall : tick_i);
  wire ovf      = step & (cnt == 16'hFFFF);
  wire trig     = exen & tfall;
  wire trig_rld = trig & ~baud & ~cmode;
  wire trig_cap = trig & ~baud & cmode;
  wire ctrl_wr  = wr_en & (addr == 3'd0);
  wire cl_wr    = wr_en & (addr == 3'd1);
  wire ch_wr    = wr_en & (addr == 3'd2);
  wire pl_wr    = wr_en & (addr == 3'd3);
  wire ph_wr    = wr_en & (addr == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cl_wr) cnt[7:0] <= wdata;
    else if (ch_wr) cnt[15:8] <= wdata;
    else if (trig_rld || (ovf && (baud || !cmode))) cnt <= cap;
    else if (step) cnt <= cnt + 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap <= '0;
    else if (pl_wr) cap[7:0] <= wdata;
    else if (ph_wr) cap[15:8] <= wdata;
    else if (trig_cap) cap <= cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tf, exf, rsel, tsel, exen, run, csrc, cmode} <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (ctrl_wr) {rsel, tsel, exen, run, csrc, cmode} <= wdata[5:0];
      tf    <= (ctrl_wr ? wdata[7] : tf) | (ovf & ~baud);
      exf   <= (ctrl_wr ? wdata[6] : exf) | trig;
      ovf_q <= ovf & baud;
    end

  always_comb
    case (addr)
      3'd0:    rdata = {tf, exf, rsel, tsel, exen, run, csrc, cmode};
      3'd1:    rdata = cnt[7:0];
      3'd2:    rdata = cnt[15:8];
      3'd3:    rdata = cap[7:0];
      3'd4:    rdata = cap[15:8];
      default: rdata = 8'h00;
    endcase

  assign rx_baud_o = rsel ? ovf_q : other_rx_clk_i;
  assign tx_baud_o = tsel ? ovf_q : other_tx_clk_i;
  assign irq_o     = irq_en_i & (tf | exf);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cl_wr && !ch_wr && !trig_rld) |=> $stable(cnt)); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cmode && !cl_wr && !ch_wr && !pl_wr && !ph_wr) |=> cnt == $past(cap)); // R4
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cmode && !baud && !cl_wr && !ch_wr) |=> cnt == 16'h0000); // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_cap && !pl_wr && !ph_wr) |=> cap == $past(cnt)); // R7
  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!exen && !exf && !ctrl_wr) |=> !exf); // R8
  AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !tf && !ctrl_wr) |=> !tf); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o); // R10

endmodule

// File: tb/test_cr_timer16.sv
`timescale 1ns/1ps
module test_cr_timer16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic tick_i = 1'b1, ext_cnt_i = 1'b0, ext_trig_i = 1'b0;
  logic other_rx = 1'b0, other_tx = 1'b0, irq_en = 1'b0;
  logic irq_o, rx_baud_o, tx_baud_o;

  cr_timer16 i_cr_timer16 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tick_i(tick_i), .ext_cnt_i(ext_cnt_i), .ext_trig_i(ext_trig_i),
    .other_rx_clk_i(other_rx), .other_tx_clk_i(other_tx), .irq_en_i(irq_en),
    .irq_o(irq_o), .rx_baud_o(rx_baud_o), .tx_baud_o(tx_baud_o));

  always #4 clk = ~clk;

  typedef struct { int src; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  logic mon_req = 1'b0;
  logic [7:0] rx_cnt = 0, tx_cnt = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rx_baud_o) rx_cnt <= rx_cnt + 8'd1;
    if (tx_baud_o) tx_cnt <= tx_cnt + 8'd1;
  end

  always @(negedge clk) begin
    item_t it;
    logic [7:0] obs;
    if (mon_req && q.size() > 0) begin
      it = q.pop_front();
      case (it.src)
        5: obs = {5'b0, irq_o, rx_baud_o, tx_baud_o};
        6: obs = rx_cnt;
        7: obs = tx_cnt;
        default: obs = rdata;
      endcase
      n_run++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s: src %0d actual %h expected %h", it.tag, it.src, obs, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(int src, logic [7:0] exp, string tag);
    item_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    if (src < 5) addr = src[2:0];
    q.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic pulse_cnt();
    ext_cnt_i = 1'b1; idle(4); ext_cnt_i = 1'b0; idle(4);
  endtask

  task automatic pulse_trig();
    ext_trig_i = 1'b1; idle(4); ext_trig_i = 1'b0; idle(5);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      if (q.size() != 0) begin
        n_fail++;
        $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rb, tb_;
    idle(3); rst_n = 1'b1; idle(1);
    for (int a = 0; a < 5; a++) chk(a, 8'h00, "R1 reset register");
    chk(5, 8'h00, "R1 reset pins");

    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h04); idle(9); wr(3'd0, 8'h00);
    chk(1, 8'd10, "R2 tick count");
    idle(3); chk(1, 8'd10, "R2 hold when stopped");
    tick_i = 1'b0; wr(3'd0, 8'h04); idle(5); wr(3'd0, 8'h00); tick_i = 1'b1;
    chk(1, 8'd10, "R2 no tick no count");

    wr(3'd0, 8'h06); pulse_cnt(); pulse_cnt(); pulse_cnt(); wr(3'd0, 8'h00);
    chk(1, 8'd13, "R3 falling edges counted");

    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h04); idle(1); wr(3'd0, 8'h00);
    chk(0, 8'h80, "R4 overflow flag");
    chk(1, 8'h34, "R4 reload low");
    chk(2, 8'h12, "R4 reload high");
    chk(5, 8'h00, "R10 irq disabled");
    irq_en = 1'b1; idle(1);
    chk(5, 8'h04, "R10 irq raised");
    wr(3'd0, 8'h00);
    chk(5, 8'h00, "R10 flag cleared");

    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h05); wr(3'd0, 8'h01);
    chk(0, 8'h81, "R5 overflow flag capture mode");
    chk(1, 8'h00, "R5 wrap low");
    chk(2, 8'h00, "R5 wrap high");
    wr(3'd0, 8'h00);

    wr(3'd1, 8'h50); wr(3'd0, 8'h08); pulse_trig();
    chk(1, 8'h34, "R6 trigger reload low");
    chk(2, 8'h12, "R6 trigger reload high");
    chk(0, 8'h48, "R6 external flag");
    chk(5, 8'h04, "R10 irq from external flag");
    wr(3'd0, 8'h00);

    wr(3'd1, 8'h50); wr(3'd2, 8'h00); pulse_trig();
    chk(1, 8'h50, "R8 no reload when disabled");
    chk(0, 8'h00, "R8 no flag when disabled");
    wr(3'd0, 8'h01); pulse_trig();
    chk(3, 8'h34, "R8 no capture when disabled");
    chk(0, 8'h01, "R8 no flag capture mode");

    wr(3'd1, 8'h77); wr(3'd0, 8'h09); pulse_trig();
    chk(3, 8'h77, "R7 capture low");
    chk(4, 8'h00, "R7 capture high");
    chk(1, 8'h77, "R7 counter unchanged");
    chk(0, 8'h49, "R7 external flag");
    wr(3'd0, 8'h00);
    irq_en = 1'b0;

    wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    rb = rx_cnt; tb_ = tx_cnt;
    wr(3'd0, 8'h24); idle(9); wr(3'd0, 8'h20); idle(2);
    chk(6, rb + 8'd5, "R9 receive pulses");
    chk(7, tb_, "R9 no transmit pulses");
    chk(0, 8'h20, "R9 no overflow flag");
    chk(1, 8'hFE, "R9 reload low");
    wr(3'd0, 8'h00);
    rb = rx_cnt; tb_ = tx_cnt;
    wr(3'd0, 8'h14); idle(3); wr(3'd0, 8'h10); idle(2);
    chk(7, tb_ + 8'd2, "R9 transmit pulses");
    chk(6, rb, "R9 no receive pulses");
    other_rx = 1'b1; other_tx = 1'b1; idle(1);
    chk(5, 8'h02, "R9 receive pass-through");
    other_rx = 1'b0; other_tx = 1'b0;
    wr(3'd0, 8'h00);

    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h04); wr(3'd1, 8'h40); wr(3'd0, 8'h00);
    chk(1, 8'h41, "R11 write beats increment");
    chk(2, 8'h00, "R11 high byte");

    idle(2);
    finish_run();
  end
endmodule